// File: doc/BRIEF.md
# Configurable Logic Cell with Carry Chaining

This block is one cell of a programmable logic fabric, written as synthesizable logic. An OR of up to sixteen product-term bits is combined in an XOR stage with a second operand that the configuration selects. The XOR result is either driven out directly or stored in a flip-flop. The flip-flop's clock comes from one of several global clocks or from a product-term clock. A polarity option makes it capture on either edge. Product terms can preset or clear it asynchronously.

Each cell also has a carry path. A 2:1 mux picks one of two dedicated carry product terms. Its select is the incoming carry, gated by a per-cell enable bit. The mux output goes to the next cell and is also one of the XOR operand choices. Cells can therefore be chained into ripple adders. To do this, each cell's carry terms encode the generate and propagate of the bit below it. Clearing the enable bit in any cell splits the chain at that cell.

The configuration is a static vector. It is loaded only while `rst_n` is low, on rising edges of `gclk[0]`. A low `rst_n` also clears the cell's flip-flops.

Top module: `pld_macrocell`

## Requirements
- R1: The XOR stage's first operand is the OR of all bits of `pt_terms`.
- R2: Configuration field `cfg_i[1:0]` selects the second XOR operand: 0 gives constant 0, 1 gives constant 1, 2 gives the local carry, and 3 gives `pt_xor`.
- R3: The local carry equals `cpt1` when the effective carry-in is 1 and `cpt0` when it is 0. `carry_out` always equals the local carry.
- R4: The effective carry-in is `carry_in` ANDed with the chain enable bit `cfg_i[2]`. When that bit is 0, `carry_in` has no effect on `carry_out` or `mc_out`.
- R5: `cfg_i[11]` set to 0 drives `mc_out` from the XOR result with no register delay. Set to 1, `mc_out` is the flip-flop output.
- R6: `cfg_i[5:3]` selects the flip-flop clock: codes 0 to 3 select `gclk[0..3]`, and code 4 (or any higher code) selects `ptclk`. Edges on clocks that are not selected do not change the flip-flop.
- R7: `cfg_i[6]` set to 0 captures on the rising edge of the selected clock; set to 1, it captures on the falling edge only.
- R8: `cfg_i[8:7]` (preset) and `cfg_i[10:9]` (clear) each pick an active-high asynchronous source: 1 selects `prc[0]`, 2 selects `prc[1]`, and 0 or 3 selects ground. A source tied to ground never acts.
- R9: When preset and clear are active together, the flip-flop is 0.
- R10: `cfg_i` is captured only on rising `gclk[0]` edges while `rst_n` is low. Changes after `rst_n` rises have no effect. While `rst_n` is low, the flip-flop is held at 0.
- R11: Eight chained cells, with each cell's carry terms taken from the bit below and the local carry as the XOR operand, form an 8-bit ripple adder. Clearing the enable in cell 4 splits it into two independent 4-bit adders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset; configuration load window |
| cfg_i | input | 12 | Static configuration vector |
| pt_terms | input | NPT | Product-term bits ORed into the XOR stage |
| pt_xor | input | 1 | Product term usable as XOR operand |
| cpt0 | input | 1 | Carry term chosen when effective carry-in is 0 |
| cpt1 | input | 1 | Carry term chosen when effective carry-in is 1 |
| prc | input | 2 | Product terms available for preset/clear |
| gclk | input | NGCLK | Global clocks; bit 0 also loads configuration |
| ptclk | input | 1 | Product-term clock |
| carry_in | input | 1 | Carry from the previous cell |
| mc_out | output | 1 | Cell output |
| carry_out | output | 1 | Carry to the next cell |

## Verification
The combinational path, the carry path and the chained adder have no register in them. Their results are checked 1 ns after the inputs change. A registered result changes only on the edge that the configuration selects. The bench therefore drives that clock by hand, samples 2 ns after the intended edge, and samples again after edges on other clocks or on the opposite polarity, where no change is expected. Preset and clear act with no clock, so they are checked 1 ns after `prc` moves. A configuration takes effect two `gclk[0]` rising edges after `rst_n` falls. The bench releases reset on a falling edge so that no load coincides with an input change.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    typedef enum logic [1:0] {
        XOP_ZERO  = 2'd0,
        XOP_ONE   = 2'd1,
        XOP_CARRY = 2'd2,
        XOP_TERM  = 2'd3
    } xop_e;

    typedef enum logic [1:0] {
        PR_GND_A = 2'd0,
        PR_TERM0 = 2'd1,
        PR_TERM1 = 2'd2,
        PR_GND_B = 2'd3
    } prsrc_e;

    // Field order fixes the bit positions of cfg_i (MSB first).
    typedef struct packed {
        logic       out_reg;
        prsrc_e     rst_src;
        prsrc_e     set_src;
        logic       fall_edge;
        logic [2:0] clk_src;
        logic       chain_en;
        xop_e       xor_op;
    } mc_cfg_t;

    localparam int CFG_W = $bits(mc_cfg_t);

endpackage

// File: rtl/pld_mc_cfg.sv
module pld_mc_cfg
    import pld_mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    output mc_cfg_t          cfg_o
);
    mc_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d = mc_cfg_t'(cfg_i);
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/pld_mc_carry.sv
module pld_mc_carry (
    input  logic carry_in,
    input  logic chain_en,
    input  logic cpt0,
    input  logic cpt1,
    output logic eff_cin,
    output logic local_carry
);
    always_comb begin
        eff_cin     = carry_in & chain_en;
        local_carry = eff_cin ? cpt1 : cpt0;
    end
endmodule

// File: rtl/pld_mc_logic.sv
module pld_mc_logic
    import pld_mc_pkg::*;
#(
    parameter int NPT = 16
) (
    input  logic [NPT-1:0] pt_terms,
    input  xop_e           xor_op,
    input  logic           local_carry,
    input  logic           pt_xor,
    output logic           xor_res
);
    logic term_sum;
    logic operand;

    always_comb begin
        term_sum = |pt_terms;
        unique case (xor_op)
            XOP_ZERO:  operand = 1'b0;
            XOP_ONE:   operand = 1'b1;
            XOP_CARRY: operand = local_carry;
            default:   operand = pt_xor;
        endcase
        xor_res = term_sum ^ operand;
    end
endmodule

// File: rtl/pld_mc_reg.sv
module pld_mc_reg
    import pld_mc_pkg::*;
#(
    parameter  int NGCLK = 4,
    localparam int SRC_N = NGCLK + 1
) (
    input  logic             rst_n,
    input  logic [NGCLK-1:0] gclk,
    input  logic             ptclk,
    input  logic [1:0]       prc,
    input  logic [2:0]       clk_src,
    input  logic             fall_edge,
    input  prsrc_e           set_src,
    input  prsrc_e           rst_src,
    input  logic             out_reg,
    input  logic             xor_res,
    output logic             set_w,
    output logic             clr_w,
    output logic             mc_out
);
    logic [SRC_N-1:0] srcs;
    logic             mclk;
    logic             rise_d, rise_q;
    logic             fall_d, fall_q;

    genvar g;
    generate
        for (g = 0; g < NGCLK; g++) begin : g_src
            assign srcs[g] = gclk[g];
        end
    endgenerate
    assign srcs[NGCLK] = ptclk;

    function automatic logic pick_src(prsrc_e s, logic [1:0] t);
        case (s)
            PR_TERM0: return t[0];
            PR_TERM1: return t[1];
            default:  return 1'b0;
        endcase
    endfunction

    always_comb begin
        if (int'(clk_src) < SRC_N) mclk = srcs[clk_src];
        else                       mclk = ptclk;
        set_w  = pick_src(set_src, prc);
        clr_w  = pick_src(rst_src, prc) | ~rst_n;
        rise_d = xor_res;
        fall_d = xor_res;
        mc_out = out_reg ? (fall_edge ? fall_q : rise_q) : xor_res;
    end

    always_ff @(posedge mclk or posedge clr_w or posedge set_w) begin
        if (clr_w)      rise_q <= 1'b0;
        else if (set_w) rise_q <= 1'b1;
        else            rise_q <= rise_d;
    end

    always_ff @(negedge mclk or posedge clr_w or posedge set_w) begin
        if (clr_w)      fall_q <= 1'b0;
        else if (set_w) fall_q <= 1'b1;
        else            fall_q <= fall_d;
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NPT   = 16,
    parameter int NGCLK = 4
) (
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [NPT-1:0]   pt_terms,
    input  logic             pt_xor,
    input  logic             cpt0,
    input  logic             cpt1,
    input  logic [1:0]       prc,
    input  logic [NGCLK-1:0] gclk,
    input  logic             ptclk,
    input  logic             carry_in,
    output logic             mc_out,
    output logic             carry_out
);
    mc_cfg_t cfg_q;
    logic    eff_cin;
    logic    local_carry;
    logic    xor_res;
    logic    set_w;
    logic    clr_w;

    pld_mc_cfg u_cfg (
        .clk   (gclk[0]),
        .rst_n (rst_n),
        .cfg_i (cfg_i),
        .cfg_o (cfg_q)
    );

    pld_mc_carry u_carry (
        .carry_in    (carry_in),
        .chain_en    (cfg_q.chain_en),
        .cpt0        (cpt0),
        .cpt1        (cpt1),
        .eff_cin     (eff_cin),
        .local_carry (local_carry)
    );

    pld_mc_logic #(.NPT(NPT)) u_logic (
        .pt_terms    (pt_terms),
        .xor_op      (cfg_q.xor_op),
        .local_carry (local_carry),
        .pt_xor      (pt_xor),
        .xor_res     (xor_res)
    );

    pld_mc_reg #(.NGCLK(NGCLK)) u_reg (
        .rst_n     (rst_n),
        .gclk      (gclk),
        .ptclk     (ptclk),
        .prc       (prc),
        .clk_src   (cfg_q.clk_src),
        .fall_edge (cfg_q.fall_edge),
        .set_src   (cfg_q.set_src),
        .rst_src   (cfg_q.rst_src),
        .out_reg   (cfg_q.out_reg),
        .xor_res   (xor_res),
        .set_w     (set_w),
        .clr_w     (clr_w),
        .mc_out    (mc_out)
    );

    assign carry_out = local_carry;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk
    import pld_mc_pkg::*;
#(
    parameter int NPT = 16
) (
    input logic           clk,
    input logic           rst_n,
    input mc_cfg_t        cfg_q,
    input logic [NPT-1:0] pt_terms,
    input logic           carry_in,
    input logic           cpt0,
    input logic           cpt1,
    input logic           clr_w,
    input logic           mc_out,
    input logic           carry_out
);
    // R4
    seg_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.chain_en |-> (carry_out == cpt0));

    // R3
    carry_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.chain_en && carry_in) |-> (carry_out == cpt1));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.out_reg && clr_w) |-> !mc_out);

    // R5
    comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.out_reg && cfg_q.xor_op == XOP_ZERO) |-> (mc_out == (|pt_terms)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_q));
endmodule

bind pld_macrocell pld_macrocell_chk #(.NPT(NPT)) u_chk (
    .clk       (gclk[0]),
    .rst_n     (rst_n),
    .cfg_q     (cfg_q),
    .pt_terms  (pt_terms),
    .carry_in  (carry_in),
    .cpt0      (cpt0),
    .cpt1      (cpt1),
    .clr_w     (clr_w),
    .mc_out    (mc_out),
    .carry_out (carry_out)
);

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;
    import pld_mc_pkg::*;

    logic        gclk0 = 1'b0;
    logic        g1 = 1'b0, g2 = 1'b0, g3 = 1'b0, ptclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_r = '0;
    logic [15:0] pt = '0;
    logic        pt_xor = 1'b0, cpt0 = 1'b0, cpt1 = 1'b0, cin = 1'b0;
    logic [1:0]  prc = 2'b00;
    logic        mc_out, carry_out;
    logic [3:0]  gclk;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    always #2.5 gclk0 = ~gclk0;
    assign gclk = {g3, g2, g1, gclk0};

    pld_macrocell u_dut (
        .rst_n(rst_n), .cfg_i(cfg_r), .pt_terms(pt), .pt_xor(pt_xor),
        .cpt0(cpt0), .cpt1(cpt1), .prc(prc), .gclk(gclk), .ptclk(ptclk),
        .carry_in(cin), .mc_out(mc_out), .carry_out(carry_out)
    );

    // Eight-cell adder chain
    logic [7:0] ca = '0, cb = '0;
    logic       ccin = 1'b0, seg_cin = 1'b0, seg_mode = 1'b0;
    logic [7:0] ch_out, ch_cout;

    function automatic logic [11:0] mk(bit oreg, logic [1:0] rs, logic [1:0] ps,
                                       bit fall, logic [2:0] cs, bit ce, logic [1:0] xo);
        return {oreg, rs, ps, fall, cs, ce, xo};
    endfunction

    genvar i;
    generate
        for (i = 0; i < 8; i++) begin : g_cell
            logic c0, c1, ci, en;
            if (i == 0) begin : g_lo
                assign c0 = ccin;
                assign c1 = ccin;
                assign ci = 1'b0;
                assign en = 1'b0;
            end else if (i == 4) begin : g_mid
                assign c0 = seg_mode ? seg_cin : (ca[i-1] & cb[i-1]);
                assign c1 = seg_mode ? seg_cin : (ca[i-1] | cb[i-1]);
                assign ci = ch_cout[i-1];
                assign en = ~seg_mode;
            end else begin : g_hi
                assign c0 = ca[i-1] & cb[i-1];
                assign c1 = ca[i-1] | cb[i-1];
                assign ci = ch_cout[i-1];
                assign en = 1'b1;
            end
            pld_macrocell u_cell (
                .rst_n(rst_n), .cfg_i(mk(0, 2'd0, 2'd0, 0, 3'd0, en, 2'd2)),
                .pt_terms({15'b0, ca[i] ^ cb[i]}), .pt_xor(1'b0),
                .cpt0(c0), .cpt1(c1), .prc(2'b00), .gclk(gclk), .ptclk(ptclk),
                .carry_in(ci), .mc_out(ch_out[i]), .carry_out(ch_cout[i])
            );
        end
    endgenerate

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic load(logic [11:0] c);
        cfg_r = c;
        rst_n = 1'b0;
        repeat (2) @(posedge gclk0);
        @(negedge gclk0);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic pulse(ref logic clk);
        clk = 1'b1; #2;
        clk = 1'b0; #2;
    endtask

    task automatic t_reset();
        cfg_r = mk(1, 2'd0, 2'd0, 0, 3'd0, 0, 2'd1);
        rst_n = 1'b0;
        repeat (2) @(posedge gclk0);
        #1 check("R10 held clear in reset", mc_out, 0);
        @(negedge gclk0);
        rst_n = 1'b1;
        @(negedge gclk0);
        check("R6 gclk0 rising capture", mc_out, 1);
    endtask

    task automatic t_comb();
        pt = '0;
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd0));
        check("R5 R2 zero operand, no terms", mc_out, 0);
        pt = 16'h8000; #1 check("R1 top term", mc_out, 1);
        pt = 16'h0101; #1 check("R1 two terms", mc_out, 1);
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd1));
        check("R2 one operand with terms", mc_out, 0);
        pt = '0; #1 check("R2 one operand no terms", mc_out, 1);
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd3));
        pt_xor = 1'b1; #1 check("R2 term operand", mc_out, 1);
        pt = 16'h0010; #1 check("R2 term operand xor", mc_out, 0);
        pt_xor = 1'b0; #1 check("R2 term operand low", mc_out, 1);
        pt = '0;
    endtask

    task automatic t_carry();
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 1, 2'd2));
        cin = 0; cpt0 = 1; cpt1 = 0; #1;
        check("R3 cin0 picks cpt0", carry_out, 1);
        check("R3 local carry to xor", mc_out, 1);
        cin = 1; #1 check("R3 cin1 picks cpt1", carry_out, 0);
        cpt0 = 0; cpt1 = 1; #1 check("R3 cin1 cpt1 high", carry_out, 1);
        check("R3 local carry out", mc_out, 1);
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd2));
        check("R4 cut chain ignores cin", carry_out, 0);
        check("R4 cut chain output", mc_out, 0);
        cpt0 = 1; cpt1 = 0; #1 check("R4 cut chain cpt0", carry_out, 1);
        cin = 0; cpt0 = 0;
    endtask

    task automatic t_clksel();
        load(mk(1, 2'd0, 2'd0, 0, 3'd2, 0, 2'd1));
        pulse(g1);
        repeat (3) @(posedge gclk0);
        #1 check("R6 unselected clocks ignored", mc_out, 0);
        pulse(g2); check("R6 gclk2 captures", mc_out, 1);
        load(mk(1, 2'd0, 2'd0, 0, 3'd4, 0, 2'd1));
        pulse(g3); check("R6 gclk3 ignored for ptclk", mc_out, 0);
        pulse(ptclk); check("R6 ptclk captures", mc_out, 1);
    endtask

    task automatic t_polarity();
        load(mk(1, 2'd0, 2'd0, 1, 3'd1, 0, 2'd1));
        g1 = 1'b1; #2 check("R7 rising edge ignored", mc_out, 0);
        g1 = 1'b0; #2 check("R7 falling edge captures", mc_out, 1);
    endtask

    task automatic t_prc();
        load(mk(1, 2'd2, 2'd1, 0, 3'd1, 0, 2'd0));
        prc = 2'b01; #1 check("R8 preset from prc0", mc_out, 1);
        prc = 2'b11; #1 check("R9 clear beats preset", mc_out, 0);
        prc = 2'b00; #1 check("R9 stays clear", mc_out, 0);
        prc = 2'b01; #1 check("R8 preset again", mc_out, 1);
        prc = 2'b00; #1 check("R8 preset held", mc_out, 1);
        load(mk(1, 2'd3, 2'd0, 0, 3'd1, 0, 2'd0));
        prc = 2'b11; #1 check("R8 ground sources ignored", mc_out, 0);
        prc = 2'b00;
        load(mk(1, 2'd0, 2'd2, 0, 3'd1, 0, 2'd0));
        prc = 2'b10; #1 check("R8 preset from prc1", mc_out, 1);
        prc = 2'b00;
    endtask

    task automatic t_cfg_hold();
        pt = '0;
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd0));
        cfg_r = mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd1);
        repeat (3) @(posedge gclk0);
        #1 check("R10 config change after reset ignored", mc_out, 0);
    endtask

    task automatic t_chain();
        logic [7:0] av[5] = '{8'h00, 8'hFF, 8'hA5, 8'h7F, 8'hC3};
        logic [7:0] bv[5] = '{8'h00, 8'h01, 8'h5A, 8'h80, 8'h3C};
        logic       cv[5] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        seg_mode = 1'b0;
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd0));
        for (int k = 0; k < 5; k++) begin
            logic [8:0] s;
            ca = av[k]; cb = bv[k]; ccin = cv[k]; #1;
            s = {1'b0, av[k]} + {1'b0, bv[k]} + {8'b0, cv[k]};
            check("R11 ripple sum", ch_out, s[7:0]);
        end
        seg_mode = 1'b1;
        load(mk(0, 2'd0, 2'd0, 0, 3'd0, 0, 2'd0));
        for (int k = 0; k < 4; k++) begin
            logic [4:0] lo, hi;
            ca = av[k+1]; cb = bv[k+1]; ccin = cv[k]; seg_cin = k[0]; #1;
            lo = {1'b0, ca[3:0]} + {1'b0, cb[3:0]} + {4'b0, ccin};
            hi = {1'b0, ca[7:4]} + {1'b0, cb[7:4]} + {4'b0, seg_cin};
            check("R11 segmented sums", ch_out, {hi[3:0], lo[3:0]});
        end
    endtask

    initial begin
        t_reset();
        t_comb();
        t_carry();
        t_clksel();
        t_polarity();
        t_prc();
        t_cfg_hold();
        t_chain();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200us;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule